// File: doc/BRIEF.md
# Frame-Synchronized Serial Transmitter with Early-Pulse Retransmission

This block sends parallel data words as a serial bit stream, one word per frame. Software or an upstream engine writes a word into a one-entry holding register through a valid/ready port. The block runs on the bit clock. A frame-sync pulse starts a frame. After a selectable data delay of 0, 1 or 2 bit clocks, the word goes out most significant bit first. An output-enable marks the bit times in which the serial line carries data. Outside those bit times the line is held at zero.

A frame-sync pulse that arrives while an element is still in flight is classed by how early it is. Let the end of the current element be the bit-clock edge on which its last bit finishes. A pulse that comes at least one bit clock before that end minus the data delay is early. An early pulse is handled in one of two ways, chosen by an ignore input:

- **Ignore input low:** the block drops the element in flight, raises a sticky sync-error flag, and sends the same element again from its first bit, counted from the new pulse.
- **Ignore input high:** the pulse is ignored and the element finishes untouched.

A pulse that is not early is taken as the start of the next frame. That frame's first bit then follows directly after the data delay, so frames can run back to back.

When a frame starts from the holding register, the held word is copied into the transmit element and the holding register is released. A retransmission always reuses that copy. A newer word waiting in the holding register is therefore never sent in place of an aborted one.

Top module: `fs_tx_framer`

## Requirements
- R1: While reset is held, and right after it, `wr_ready_o` is 1 and `sdo_en_o`, `sdo_o` and `sync_err_o` are 0.
- R2: A write is accepted on a clock edge where `wr_valid_i` and `wr_ready_o` are both 1. `wr_ready_o` is 0 from the next cycle on. It returns to 1 in the cycle after the frame-start edge that copies the word out for sending.
- R3: Let a frame start on the edge where `fsync_i` is sampled 1 and data delay d is set (`dly_i` code 0, 1 or 2). The first bit is the word's most significant bit, and it is on `sdo_o` in the cycle after edge t+d. Bit k (k = 0 for the MSB) follows in the cycle after edge t+d+k.
- R4: For an element sent without disturbance, `sdo_en_o` is 1 for exactly W consecutive cycles, with W = 8 by default. `sdo_o` is 0 whenever `sdo_en_o` is 0.
- R5: A pulse is early when the block is in its delay phase, or is shifting with more than d bits left after the current one. For example, a pulse one edge before end-minus-d is early. When `ignore_i` is 0, an early pulse aborts the element, and `sync_err_o` reads 1 in the cycle after that edge.
- R6: After an abort, the same element is sent again from its MSB, with its first bit in the cycle after edge p+d, where p is the edge of the early pulse.
- R7: When `ignore_i` is 1, an early pulse does not change the element in flight and does not set `sync_err_o`.
- R8: `sync_err_o` stays 1 until `err_clr_i` is sampled 1. It then reads 0 from the next cycle, unless a new abort happens on that same edge.
- R9: A pulse at or after end-minus-d is not an error. The next element's first bit follows the previous element's last bit with no gap.
- R10: A word written while an element is in flight stays in the holding register through a retransmission (`wr_ready_o` stays 0). That word is sent only in the frame after the retransmitted element.
- R11: A frame-sync pulse that finds the holding register empty, with nothing in flight, sends nothing: `sdo_en_o` stays 0.
- R12: A `dly_i` code of 3 behaves as a delay of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame-sync pulse, sampled on the clock edge |
| ignore_i | input | 1 | 1: ignore early frame-sync pulses |
| dly_i | input | 2 | Data delay in bit clocks (0, 1, 2; 3 acts as 2) |
| wr_valid_i | input | 1 | Write request into the holding register |
| wr_data_i | input | W | Word to be sent |
| wr_ready_o | output | 1 | Holding register is free |
| sdo_o | output | 1 | Serial data, MSB first |
| sdo_en_o | output | 1 | Serial data valid / drive enable |
| sync_err_o | output | 1 | Sticky transmit sync-error flag |
| err_clr_i | input | 1 | Clears the sync-error flag |

## Verification
Every result is registered once behind the edge that causes it:

- **Frame start:** the MSB of an element is due in the cycle after the frame-sync edge plus d further edges.
- **Following bits:** each later bit is due one cycle after the one before it.
- **Error flag and write-ready:** the error flag, the drop of write-ready after a write, and the release of write-ready at frame start are all due in the cycle right after their edge.

The bench drives every stimulus for exactly one edge and samples on the falling edge between edges. It counts those edges to place each expected bit. Early pulses are placed relative to the computed end of the element:

- one edge too early, to hit the boundary;
- in the middle of the element;
- exactly at end-minus-d, which must not count as early.

All of these are swept over each delay code.

// File: rtl/fs_tx_pkg.sv
package fs_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DLY   = 2'd1,
    ST_SHIFT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/fs_tx_holding.sv
module fs_tx_holding #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_valid_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         take_i,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  logic         full_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (wr_valid_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= wr_data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/fs_sync_class.sv
// Classifies a frame-sync pulse against the element currently in flight.
module fs_sync_class
  import fs_tx_pkg::*;
#(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  tx_state_e     state_i,
  input  logic [IW-1:0] idx_i,
  input  logic [1:0]    dly_i,
  input  logic          fsync_i,
  input  logic          ignore_i,
  output logic          start_now_o,
  output logic          pend_o,
  output logic          abort_o
);
  logic [IW-1:0] dly_ext;
  logic          early;

  assign dly_ext = {{(IW-2){1'b0}}, dly_i};

  always_comb begin
    start_now_o = 1'b0;
    pend_o      = 1'b0;
    early       = 1'b0;
    unique case (state_i)
      ST_IDLE:  start_now_o = fsync_i;
      ST_DLY:   early = fsync_i;
      ST_SHIFT: begin
        // idx_i bits remain after the current one
        if (idx_i > dly_ext)   early       = fsync_i;
        else if (idx_i == '0)  start_now_o = fsync_i;
        else                   pend_o      = fsync_i;
      end
      default: ;
    endcase
  end

  assign abort_o = early && !ignore_i;
endmodule

// File: rtl/fs_tx_seq.sv
module fs_tx_seq
  import fs_tx_pkg::*;
#(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_now_i,
  input  logic          pend_i,
  input  logic          abort_i,
  input  logic [1:0]    dly_i,
  input  logic          hold_full_i,
  input  logic [W-1:0]  hold_data_i,
  output logic          take_o,
  output tx_state_e     state_o,
  output logic [IW-1:0] idx_o,
  output logic          sdo_o,
  output logic          sdo_en_o
);
  localparam logic [IW-1:0] IdxTop = IW'(W - 1);

  tx_state_e     state_q, state_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [1:0]    cnt_q, cnt_n, pcnt_q, pcnt_n, rem;
  logic [W-1:0]  elem_q, elem_n;
  logic          pend_q, pend_n, go, load;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    cnt_n   = cnt_q;
    elem_n  = elem_q;
    pend_n  = pend_q;
    pcnt_n  = pcnt_q;
    go      = 1'b0;
    load    = 1'b0;
    rem     = '0;
    take_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_now_i) begin go = 1'b1; rem = dly_i; load = 1'b1; end
      ST_DLY: begin
        if (abort_i) begin go = 1'b1; rem = dly_i; end
        else if (cnt_q == 2'd1) begin state_n = ST_SHIFT; idx_n = IdxTop; end
        else cnt_n = cnt_q - 2'd1;
      end
      ST_SHIFT: begin
        pend_n = 1'b0;
        if (abort_i) begin
          go = 1'b1; rem = dly_i;
        end else if (idx_q == '0) begin
          if (start_now_i)  begin go = 1'b1; rem = dly_i;  load = 1'b1; end
          else if (pend_q)  begin go = 1'b1; rem = pcnt_q; load = 1'b1; end
          else state_n = ST_IDLE;
        end else begin
          idx_n  = idx_q - 1'b1;
          pend_n = pend_q | pend_i;
          if (pend_i) pcnt_n = dly_i - idx_q[1:0];
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (go) begin
      if (load && !hold_full_i) begin
        state_n = ST_IDLE;
      end else begin
        take_o = load;
        if (load) elem_n = hold_data_i;  // retransmission keeps elem_q
        if (rem == 2'd0) begin state_n = ST_SHIFT; idx_n = IdxTop; end
        else             begin state_n = ST_DLY;   cnt_n = rem;    end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      elem_q  <= '0;
      pend_q  <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      cnt_q   <= cnt_n;
      elem_q  <= elem_n;
      pend_q  <= pend_n;
      pcnt_q  <= pcnt_n;
    end
  end

  assign state_o  = state_q;
  assign idx_o    = idx_q;
  assign sdo_en_o = (state_q == ST_SHIFT);
  assign sdo_o    = sdo_en_o & elem_q[idx_q];
endmodule

// File: rtl/fs_tx_framer.sv
module fs_tx_framer
  import fs_tx_pkg::*;
#(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fsync_i,
  input  logic         ignore_i,
  input  logic [1:0]   dly_i,
  input  logic         wr_valid_i,
  input  logic [W-1:0] wr_data_i,
  output logic         wr_ready_o,
  output logic         sdo_o,
  output logic         sdo_en_o,
  output logic         sync_err_o,
  input  logic         err_clr_i
);
  logic [1:0]    dly_eff;
  logic          hold_full, take, start_now, pend, abort;
  logic [W-1:0]  hold_data;
  tx_state_e     state;
  logic [IW-1:0] idx;
  logic          err_q;

  assign dly_eff = (dly_i == 2'd3) ? 2'd2 : dly_i;

  fs_tx_holding #(.W(W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .take_i(take), .full_o(hold_full), .data_o(hold_data)
  );

  fs_sync_class #(.W(W)) u_class (
    .state_i(state), .idx_i(idx), .dly_i(dly_eff),
    .fsync_i(fsync_i), .ignore_i(ignore_i),
    .start_now_o(start_now), .pend_o(pend), .abort_o(abort)
  );

  fs_tx_seq #(.W(W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_now_i(start_now), .pend_i(pend), .abort_i(abort),
    .dly_i(dly_eff), .hold_full_i(hold_full), .hold_data_i(hold_data),
    .take_o(take), .state_o(state), .idx_o(idx),
    .sdo_o(sdo_o), .sdo_en_o(sdo_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (abort)     err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign sync_err_o = err_q;
  assign wr_ready_o = !hold_full;
endmodule

// File: rtl/fs_tx_framer_chk.sv
module fs_tx_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fsync_i,
  input logic ignore_i,
  input logic wr_valid_i,
  input logic wr_ready_o,
  input logic sdo_o,
  input logic sdo_en_o,
  input logic sync_err_o,
  input logic err_clr_i
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!sdo_en_o && !sync_err_o && wr_ready_o)
        else $error("reset state violated");
    end
  end

  p_ready_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_ready_o |=> !wr_ready_o);

  p_line_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_en_o |-> !sdo_o);

  p_err_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_err_o) |-> $past(fsync_i));

  p_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_err_o) |-> !$past(ignore_i));

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o && !err_clr_i |=> sync_err_o);
endmodule

bind fs_tx_framer fs_tx_framer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fsync_i(fsync_i), .ignore_i(ignore_i),
  .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .sdo_o(sdo_o),
  .sdo_en_o(sdo_en_o), .sync_err_o(sync_err_o), .err_clr_i(err_clr_i)
);

// File: tb/fs_tx_framer_test.sv
module fs_tx_framer_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni, fsync, ignore, wr_valid, err_clr;
  logic [1:0]   dly;
  logic [W-1:0] wr_data;
  logic         wr_ready, sdo, sdo_en, sync_err;
  int           checks = 0;
  int           fails  = 0;

  always #4 clk = ~clk;

  fs_tx_framer #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .fsync_i(fsync), .ignore_i(ignore),
    .dly_i(dly), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_ready_o(wr_ready), .sdo_o(sdo), .sdo_en_o(sdo_en),
    .sync_err_o(sync_err), .err_clr_i(err_clr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Tasks are entered and left at a falling edge; each stimulus covers one rising edge.
  task automatic pulse();
    fsync = 1'b1; @(negedge clk); fsync = 1'b0;
  endtask

  task automatic write(input logic [W-1:0] v);
    wr_valid = 1'b1; wr_data = v; @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic clear_err();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic collect(input int d, input int gk, output logic [W-1:0] w,
                         output int ens, output int pre);
    pre = 0; ens = 0; w = '0;
    for (int i = 0; i < d; i++) begin pre += int'(sdo_en); @(negedge clk); end
    for (int k = 0; k < W; k++) begin
      w[W-1-k] = sdo; ens += int'(sdo_en);
      if (k == gk) fsync = 1'b1;
      @(negedge clk);
      fsync = 1'b0;
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] w, a, b;
    int ens, pre, cnt;
    logic rec_sdo [2*W+3];
    logic rec_en  [2*W+3];
    rst_ni = 1'b0; fsync = 0; ignore = 0; wr_valid = 0; err_clr = 0; dly = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(wr_ready && !sdo_en && !sdo && !sync_err, "R1 in reset", {wr_ready, sdo_en, sdo, sync_err}, 4'b1000);
    rst_ni = 1'b1; @(negedge clk);
    chk(wr_ready && !sdo_en && !sdo && !sync_err, "R1 after reset", {wr_ready, sdo_en, sdo, sync_err}, 4'b1000);

    // Plain frames over every delay code: R2 R3 R4 R12
    for (int code = 0; code < 4; code++) begin
      for (int i = 0; i < 4; i++) begin
        int d;
        d = (code > 2) ? 2 : code;
        dly = 2'(code);
        a = W'(8'h5A ^ (code * 53 + i * 29));
        write(a);
        chk(!wr_ready, "R2 ready low after write", wr_ready, 0);
        pulse();
        chk(wr_ready, "R2 ready after frame start", wr_ready, 1);
        collect(d, -1, w, ens, pre);
        chk(w == a, (code == 3) ? "R12 code3 data" : "R3 data MSB first", w, a);
        chk(ens == W && pre == 0, "R4 enable window", ens * 16 + pre, W * 16);
        chk(!sdo_en && !sdo, "R4 line idle after element", {sdo_en, sdo}, 0);
        chk(!sync_err, "R9 no error on clean frame", sync_err, 0);
      end
    end

    // R11: pulse with empty holding register
    dly = 2'd0;
    pulse();
    cnt = 0;
    for (int i = 0; i < W + 3; i++) begin cnt += int'(sdo_en); @(negedge clk); end
    chk(cnt == 0, "R11 nothing sent when empty", cnt, 0);

    for (int d = 0; d < 3; d++) begin
      dly = 2'(d);
      // Mid-element abort with new data waiting: R5 R6 R8 R10
      a = W'(8'hC3 + d); b = W'(8'h3C ^ d);
      write(a); pulse(); write(b);
      repeat (d + 1) @(negedge clk);
      pulse();
      chk(sync_err, "R5 error after early pulse", sync_err, 1);
      chk(!wr_ready, "R10 holding kept through abort", wr_ready, 0);
      collect(d, -1, w, ens, pre);
      chk(w == a && ens == W && pre == 0, "R6 same element resent", w, a);
      chk(!sdo_en, "R6 idle after resend", sdo_en, 0);
      chk(sync_err, "R8 error sticky", sync_err, 1);
      pulse();
      collect(d, -1, w, ens, pre);
      chk(w == b, "R10 waiting word sent next", w, b);
      chk(sync_err, "R8 still sticky", sync_err, 1);
      clear_err();
      chk(!sync_err, "R8 cleared", sync_err, 0);

      // Boundary: pulse one edge before end-minus-d is early: R5 R6
      a = W'(8'h96 >> d);
      write(a); pulse();
      repeat (W - 2) @(negedge clk);
      pulse();
      chk(sync_err, "R5 one-clock-early boundary", sync_err, 1);
      collect(d, -1, w, ens, pre);
      chk(w == a && ens == W, "R6 resend after boundary abort", w, a);
      clear_err();

      // Pulse exactly at end-minus-d: seamless next element, R9
      a = W'(8'hE1 ^ (d * 7)); b = W'(8'h1E + d);
      write(a); pulse();
      fork
        begin write(b); repeat (W - 2) @(negedge clk); pulse(); end
        begin
          for (int i = 0; i < 2*W + d + 1; i++) begin
            rec_sdo[i] = sdo; rec_en[i] = sdo_en; @(negedge clk);
          end
        end
      join
      cnt = 0; w = '0;
      for (int k = 0; k < W; k++) w[W-1-k] = rec_sdo[d + k];
      chk(w == a, "R9 first element", w, a);
      w = '0;
      for (int k = 0; k < W; k++) w[W-1-k] = rec_sdo[d + W + k];
      chk(w == b, "R9 back-to-back element", w, b);
      for (int i = 0; i < 2*W + d + 1; i++) cnt += int'(rec_en[i]);
      chk(cnt == 2*W && !rec_en[2*W + d], "R9 continuous enable", cnt, 2*W);
      chk(!sync_err, "R9 no error at end-minus-d", sync_err, 0);

      // Ignore early pulses: R7
      ignore = 1'b1;
      a = W'(8'hB4 ^ d);
      write(a); pulse();
      collect(d, 2, w, ens, pre);
      chk(w == a && ens == W, "R7 element completes", w, a);
      chk(!sync_err && !sdo_en, "R7 no error when ignored", {sync_err, sdo_en}, 0);
      ignore = 1'b0;
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule